// File: doc/BRIEF.md
# Texture Word Buffer with Packet Parser

The block collects 32-bit words written by a host into a word buffer. When the host issues a flush, the block walks the buffered words as a chain of texture packets. For each packet it offers an upload request to a downstream texture upload unit. The request carries the packet header word and the buffer index at which the packet's texel words begin. The upload unit fetches those texel words through a read port on the buffer. When the walk is over, the buffer is emptied.

A second, texture-port input works in one of two modes, selected by a static strap.

- **Indirect mode:** the port gathers a ROM address and a header over three writes, then offers an upload request that names the ROM as the data source.
- **ROM-fill mode:** one port write gives a ROM address. The block copies a whole packet from the ROM into the word buffer, as if the host had written it.

A buffer overflow raises an error flag. The flag stays set until the end-of-frame strobe clears it.

The capacity is the `DEPTH` parameter. The chip instance uses 262144 words; the default is smaller.

Top module: `tex_upload_fifo`

## Requirements
- R1: After reset the buffer is empty, `up_valid` is 0, `overflow_err` is 0 and `rom_rd_en` is 0. Accepted words are stored at consecutive indices starting at 0. `rd_data` returns the word at `rd_addr` one clock after the address is presented.
- R2: A write while the buffer holds `DEPTH` words is dropped, and the stored words are unchanged. Such a write sets `overflow_err`. Further overflows leave the flag at 1.
- R3: A `frame_end` pulse clears `overflow_err`. If an overflow happens in the same cycle as `frame_end`, the flag stays 1.
- R4: A flush parses packets only when the buffer holds more than 2 words. Whether or not it parses, the word count returns to 0, so the next accepted word goes to index 0.
- R5: A packet that starts at index i has a length in words of (2 + w/2)/4, using integer division, where w is the word at index i. Its header is the word at i+1, and `up_start` is i+2.
- R6: Parsing starts at index 0 and continues while i < count − 2, where count is the number of stored words. After each accepted request, i advances by the packet length. A packet whose length is 0 ends the walk and issues no request.
- R7: A request is transferred when `up_valid` and `up_ready` are both 1 at a clock edge. While `up_ready` is 0, `up_valid` stays 1 and `up_header`, `up_start` and `up_from_rom` stay stable.
- R8: A flush that arrives while a flush is being processed is held and runs after the current one completes. The held flush does not end the current walk or issue requests. Buffer writes are dropped, without setting the error flag, from the flush cycle until the count is cleared.
- R9: In indirect mode (`rom_fill_mode`=0), port writes are handled as follows:
  - The 1st write stores bits [23:0] of the data as the ROM address.
  - The 2nd write stores the header.
  - The 3rd write discards its data and resets the collection. It also raises a request with `up_from_rom`=1, `up_rom_addr` set to the stored address, and `up_header` set to the stored header.
- R10: A ROM request wins over a waiting parser request. A 3rd write that arrives while an earlier ROM request is still waiting raises no new request, but it still resets the collection.
- R11: In ROM-fill mode (`rom_fill_mode`=1), one port write gives a ROM address in data bits [23:0]. The block reads the ROM (one clock of read latency) and appends n = (2 + rom[a]/2)/4 words, taken from rom[a] to rom[a+n−1], to the buffer. A host write in the same cycle, or a flush being processed, delays the copy. It loses no word.
- R12: In ROM-fill mode, a count of 0 copies nothing. Port writes that arrive while a copy is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host word write strobe |
| wr_data | input | 32 | Host word |
| tport_valid | input | 1 | Texture-port write strobe |
| tport_data | input | 32 | Texture-port data |
| rom_fill_mode | input | 1 | Static strap: 1 = ROM-fill mode, 0 = indirect mode |
| flush | input | 1 | Flush strobe |
| frame_end | input | 1 | End-of-frame strobe |
| rom_rd_en | output | 1 | ROM read request |
| rom_rd_addr | output | 24 | ROM word address |
| rom_rd_data | input | 32 | ROM word, one clock after the request |
| rd_addr | input | AW | Buffer index for the upload unit's reads |
| rd_data | output | 32 | Buffer word at the previous cycle's `rd_addr` |
| up_valid | output | 1 | Upload request valid |
| up_ready | input | 1 | Upload unit accepts the request |
| up_header | output | 32 | Texture header |
| up_from_rom | output | 1 | 1 = data is read from the ROM, 0 = data is read from the buffer |
| up_start | output | AW | Buffer index of the first texel word |
| up_rom_addr | output | 24 | ROM address of the texel data |
| overflow_err | output | 1 | Sticky overflow flag |

## Verification
The hardest states to reach from the ports are a buffer filled to exactly `DEPTH` words at the moment `frame_end` arrives, and a second flush landing while the first walk is stalled. The bench builds the block with a small `DEPTH`, fills it word by word and then pairs an extra write with a `frame_end` pulse. To stall the walk, the bench holds `up_ready` low, issues the second flush and a stray write, and then releases the handshake. The same low `up_ready` keeps a ROM request and a parser request waiting side by side, so the bench can observe which one wins.

// File: rtl/tex_pkg.sv
package tex_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ROM_AW = 24;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ROM_AW-1:0] rom_addr_t;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_ADDR0,
        PS_LEN,
        PS_HDR,
        PS_OFFER,
        PS_CLEAR
    } parse_state_e;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_REQ,
        CS_CAP,
        CS_PUT
    } copy_state_e;

    typedef struct packed {
        word_t     header;
        logic      from_rom;
        rom_addr_t rom_addr;
    } up_req_t;

    // Packet length in words from the leading byte-count word.
    function automatic word_t pkt_words(input word_t w0);
        return ((w0 >> 1) + 32'd2) >> 2;
    endfunction

endpackage

// File: rtl/tex_word_store.sv
module tex_word_store
    import tex_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  word_t         wr_data,
    input  logic          clr,
    input  logic          frame_end,
    input  logic [AW-1:0] prd_addr,
    output word_t         prd_data,
    input  logic [AW-1:0] ext_rd_addr,
    output word_t         ext_rd_data,
    output logic [CW-1:0] count,
    output logic          ovf_evt,
    output logic          err
);

    word_t mem [DEPTH];
    logic  full;
    logic  accept;

    assign full    = (count == CW'(DEPTH));
    assign ovf_evt = wr_en && full;
    assign accept  = wr_en && !full && !clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            if (clr)
                count <= '0;
            else if (accept)
                count <= count + CW'(1);
            if (ovf_evt)
                err <= 1'b1;
            else if (frame_end)
                err <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (accept)
            mem[count[AW-1:0]] <= wr_data;
        prd_data    <= mem[prd_addr];
        ext_rd_data <= mem[ext_rd_addr];
    end

endmodule

// File: rtl/tex_pkt_parser.sv
module tex_pkt_parser
    import tex_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] count,
    output logic [AW-1:0] rd_addr,
    input  word_t         rd_data,
    output logic          req_valid,
    output word_t         req_header,
    output logic [AW-1:0] req_start,
    input  logic          grant,
    output logic          block,
    output logic          clr
);

    parse_state_e  state;
    logic [CW-1:0] idx;
    logic [CW-1:0] lim;
    word_t         plen;
    word_t         hdr;
    logic          pend;
    logic          go;
    logic [WORD_W:0] nxt;

    assign go   = flush || pend;
    assign nxt  = {1'b0, plen} + (WORD_W+1)'(idx);

    assign block = (state != PS_IDLE) || go;
    assign clr   = (state == PS_CLEAR) ||
                   ((state == PS_IDLE) && go && (count <= CW'(2)));

    always_comb begin
        rd_addr = idx[AW-1:0];
        if (state == PS_LEN)
            rd_addr = idx[AW-1:0] + AW'(1);
    end

    assign req_valid  = (state == PS_OFFER);
    assign req_header = hdr;
    assign req_start  = idx[AW-1:0] + AW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_IDLE;
            idx   <= '0;
            lim   <= '0;
            plen  <= '0;
            hdr   <= '0;
            pend  <= 1'b0;
        end else begin
            if (flush && (state != PS_IDLE))
                pend <= 1'b1;
            unique case (state)
                PS_IDLE: begin
                    if (go) begin
                        pend <= 1'b0;
                        if (count > CW'(2)) begin
                            idx   <= '0;
                            lim   <= count - CW'(2);
                            state <= PS_ADDR0;
                        end
                    end
                end
                PS_ADDR0: state <= PS_LEN;
                PS_LEN: begin
                    plen <= pkt_words(rd_data);
                    if (pkt_words(rd_data) == '0)
                        state <= PS_CLEAR;
                    else
                        state <= PS_HDR;
                end
                PS_HDR: begin
                    hdr   <= rd_data;
                    state <= PS_OFFER;
                end
                PS_OFFER: begin
                    if (grant) begin
                        if (nxt < (WORD_W+1)'(lim)) begin
                            idx   <= CW'(nxt);
                            state <= PS_ADDR0;
                        end else begin
                            state <= PS_CLEAR;
                        end
                    end
                end
                PS_CLEAR: state <= PS_IDLE;
                default:  state <= PS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tex_rom_port.sv
module tex_rom_port
    import tex_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fill_mode,
    input  logic      tp_valid,
    input  word_t     tp_data,
    output logic      rom_rd_en,
    output rom_addr_t rom_rd_addr,
    input  word_t     rom_rd_data,
    input  logic      put_ok,
    output logic      put_en,
    output word_t     put_data,
    output logic      req_valid,
    output word_t     req_header,
    output rom_addr_t req_rom_addr,
    input  logic      grant
);

    // Indirect collection
    logic [1:0] sel;
    rom_addr_t  a_reg;
    word_t      h_reg;
    logic       pend;
    word_t      p_hdr;
    rom_addr_t  p_addr;
    logic       trig;
    logic       unused_tp_hi;

    assign unused_tp_hi = ^tp_data[WORD_W-1:ROM_AW];
    assign trig = !fill_mode && tp_valid && (sel == 2'd2);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel    <= 2'd0;
            a_reg  <= '0;
            h_reg  <= '0;
            pend   <= 1'b0;
            p_hdr  <= '0;
            p_addr <= '0;
        end else begin
            if (!fill_mode && tp_valid) begin
                unique case (sel)
                    2'd0: begin
                        a_reg <= tp_data[ROM_AW-1:0];
                        sel   <= 2'd1;
                    end
                    2'd1: begin
                        h_reg <= tp_data;
                        sel   <= 2'd2;
                    end
                    default: sel <= 2'd0;
                endcase
            end
            if (grant)
                pend <= 1'b0;
            if (trig && (!pend || grant)) begin
                pend   <= 1'b1;
                p_hdr  <= h_reg;
                p_addr <= a_reg;
            end
        end
    end

    assign req_valid    = pend;
    assign req_header   = p_hdr;
    assign req_rom_addr = p_addr;

    // ROM-fill copy engine
    copy_state_e cstate;
    rom_addr_t   base;
    word_t       k;
    word_t       n;
    word_t       hold;

    assign rom_rd_en   = (cstate == CS_REQ);
    assign rom_rd_addr = base + k[ROM_AW-1:0];
    assign put_en      = (cstate == CS_PUT) && put_ok;
    assign put_data    = hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            cstate <= CS_IDLE;
            base   <= '0;
            k      <= '0;
            n      <= '0;
            hold   <= '0;
        end else begin
            unique case (cstate)
                CS_IDLE: begin
                    if (fill_mode && tp_valid) begin
                        base   <= tp_data[ROM_AW-1:0];
                        k      <= '0;
                        cstate <= CS_REQ;
                    end
                end
                CS_REQ: cstate <= CS_CAP;
                CS_CAP: begin
                    hold <= rom_rd_data;
                    if (k == '0) begin
                        n <= pkt_words(rom_rd_data);
                        if (pkt_words(rom_rd_data) == '0)
                            cstate <= CS_IDLE;
                        else
                            cstate <= CS_PUT;
                    end else begin
                        cstate <= CS_PUT;
                    end
                end
                CS_PUT: begin
                    if (put_ok) begin
                        k <= k + 32'd1;
                        if (k + 32'd1 == n)
                            cstate <= CS_IDLE;
                        else
                            cstate <= CS_REQ;
                    end
                end
                default: cstate <= CS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tex_upload_fifo.sv
module tex_upload_fifo
    import tex_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 tport_valid,
    input  logic [WORD_W-1:0]    tport_data,
    input  logic                 rom_fill_mode,
    input  logic                 flush,
    input  logic                 frame_end,
    output logic                 rom_rd_en,
    output logic [ROM_AW-1:0]    rom_rd_addr,
    input  logic [WORD_W-1:0]    rom_rd_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 up_valid,
    input  logic                 up_ready,
    output logic [WORD_W-1:0]    up_header,
    output logic                 up_from_rom,
    output logic [AW-1:0]        up_start,
    output logic [ROM_AW-1:0]    up_rom_addr,
    output logic                 overflow_err
);

    logic [CW-1:0] count;
    logic          ovf_evt;
    logic          cnt_clr;
    logic          pblock;
    logic [AW-1:0] p_rd_addr;
    word_t         p_rd_data;
    logic          p_valid;
    word_t         p_header;
    logic [AW-1:0] p_start;
    logic          p_grant;
    logic          r_valid;
    word_t         r_header;
    rom_addr_t     r_addr;
    logic          r_grant;
    logic          c_put;
    word_t         c_put_data;
    logic          put_ok;
    logic          st_wr_en;
    word_t         st_wr_data;
    up_req_t       sel_req;

    assign put_ok     = !wr_valid && !pblock;
    assign st_wr_en   = (wr_valid && !pblock) || c_put;
    assign st_wr_data = c_put ? c_put_data : wr_data;

    tex_word_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (st_wr_en),
        .wr_data     (st_wr_data),
        .clr         (cnt_clr),
        .frame_end   (frame_end),
        .prd_addr    (p_rd_addr),
        .prd_data    (p_rd_data),
        .ext_rd_addr (rd_addr),
        .ext_rd_data (rd_data),
        .count       (count),
        .ovf_evt     (ovf_evt),
        .err         (overflow_err)
    );

    tex_pkt_parser #(.AW(AW), .CW(CW)) u_parser (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .count      (count),
        .rd_addr    (p_rd_addr),
        .rd_data    (p_rd_data),
        .req_valid  (p_valid),
        .req_header (p_header),
        .req_start  (p_start),
        .grant      (p_grant),
        .block      (pblock),
        .clr        (cnt_clr)
    );

    tex_rom_port u_rom (
        .clk          (clk),
        .rst          (rst),
        .fill_mode    (rom_fill_mode),
        .tp_valid     (tport_valid),
        .tp_data      (tport_data),
        .rom_rd_en    (rom_rd_en),
        .rom_rd_addr  (rom_rd_addr),
        .rom_rd_data  (rom_rd_data),
        .put_ok       (put_ok),
        .put_en       (c_put),
        .put_data     (c_put_data),
        .req_valid    (r_valid),
        .req_header   (r_header),
        .req_rom_addr (r_addr),
        .grant        (r_grant)
    );

    // ROM requests are older by construction of the host flow; they go first.
    assign r_grant = up_ready && r_valid;
    assign p_grant = up_ready && p_valid && !r_valid;

    always_comb begin
        if (r_valid) begin
            sel_req.header   = r_header;
            sel_req.from_rom = 1'b1;
            sel_req.rom_addr = r_addr;
        end else begin
            sel_req.header   = p_header;
            sel_req.from_rom = 1'b0;
            sel_req.rom_addr = '0;
        end
    end

    assign up_valid    = r_valid || p_valid;
    assign up_header   = sel_req.header;
    assign up_from_rom = sel_req.from_rom;
    assign up_rom_addr = sel_req.rom_addr;
    assign up_start    = r_valid ? '0 : p_start;

endmodule

// File: rtl/tex_upload_fifo_chk.sv
module tex_upload_fifo_chk #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW = 10,
    parameter int unsigned CW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_end,
    input logic          up_valid,
    input logic          up_ready,
    input logic [31:0]   up_header,
    input logic [AW-1:0] up_start,
    input logic          up_from_rom,
    input logic          overflow_err,
    input logic          ovf_evt,
    input logic          cnt_clr,
    input logic          pblock,
    input logic          r_valid,
    input logic [CW-1:0] count
);

    p_hold_req_r7: assert property (@(posedge clk) disable iff (rst)
        up_valid && !up_ready |=> up_valid && $stable(up_header) &&
                                  $stable(up_start) && $stable(up_from_rom));

    p_err_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        overflow_err && !frame_end |=> overflow_err);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_err_clear_r3: assert property (@(posedge clk) disable iff (rst)
        frame_end && !ovf_evt |=> !overflow_err);

    p_count_reset_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> count == '0);

    p_write_block_r8: assert property (@(posedge clk) disable iff (rst)
        pblock && !cnt_clr |=> $stable(count));

    p_rom_first_r10: assert property (@(posedge clk) disable iff (rst)
        r_valid |-> up_valid && up_from_rom);

endmodule

bind tex_upload_fifo tex_upload_fifo_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_end    (frame_end),
    .up_valid     (up_valid),
    .up_ready     (up_ready),
    .up_header    (up_header),
    .up_start     (up_start),
    .up_from_rom  (up_from_rom),
    .overflow_err (overflow_err),
    .ovf_evt      (ovf_evt),
    .cnt_clr      (cnt_clr),
    .pblock       (pblock),
    .r_valid      (r_valid),
    .count        (count)
);

// File: tb/tb_tex_upload_fifo.sv
module tb_tex_upload_fifo;

    localparam int DEPTH = 16;
    localparam int AW = 4;
    localparam int NV = 7;

    // {word0 of packet A, word0 of packet B, words written, expected requests}
    localparam logic [127:0] VEC [NV] = '{
        {32'd14, 32'd14, 32'd4,  32'd1},
        {32'd30, 32'd22, 32'd10, 32'd3},
        {32'd0,  32'd0,  32'd6,  32'd0},
        {32'd14, 32'd14, 32'd2,  32'd0},
        {32'd14, 32'd14, 32'd3,  32'd1},
        {32'd5,  32'd0,  32'd5,  32'd2},
        {32'd18, 32'd0,  32'd8,  32'd1}
    };

    logic clk = 0;
    logic rst = 1;
    logic wr_valid = 0;
    logic [31:0] wr_data = 0;
    logic tport_valid = 0;
    logic [31:0] tport_data = 0;
    logic rom_fill_mode = 0;
    logic flush = 0;
    logic frame_end = 0;
    logic rom_rd_en;
    logic [23:0] rom_rd_addr;
    logic [31:0] rom_rd_data;
    logic [AW-1:0] rd_addr = 0;
    logic [31:0] rd_data;
    logic up_valid;
    logic up_ready = 1;
    logic [31:0] up_header;
    logic up_from_rom;
    logic [AW-1:0] up_start;
    logic [23:0] up_rom_addr;
    logic overflow_err;

    always #4 clk = ~clk;

    tex_upload_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .tport_valid(tport_valid), .tport_data(tport_data),
        .rom_fill_mode(rom_fill_mode), .flush(flush), .frame_end(frame_end),
        .rom_rd_en(rom_rd_en), .rom_rd_addr(rom_rd_addr), .rom_rd_data(rom_rd_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .up_valid(up_valid), .up_ready(up_ready),
        .up_header(up_header), .up_from_rom(up_from_rom), .up_start(up_start),
        .up_rom_addr(up_rom_addr), .overflow_err(overflow_err)
    );

    // ROM model, one clock read latency
    logic [31:0] rom_img [64];
    always_ff @(posedge clk) if (rom_rd_en) rom_rd_data <= rom_img[rom_rd_addr[5:0]];

    // Request log, sampled after inputs settle at the falling edge
    logic [31:0] lg_hdr [64];
    int          lg_start [64];
    logic        lg_rom [64];
    logic [23:0] lg_raddr [64];
    int          lg_n = 0;
    always begin
        @(negedge clk);
        #1;
        if (up_valid && up_ready && lg_n < 64) begin
            lg_hdr[lg_n]   = up_header;
            lg_start[lg_n] = int'(up_start);
            lg_rom[lg_n]   = up_from_rom;
            lg_raddr[lg_n] = up_rom_addr;
            lg_n++;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] words [32];
    logic [31:0] exp_hdr [32];
    int          exp_start [32];
    int          exp_n;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_ne(input string req, input logic [31:0] act, input logic [31:0] bad);
        n_chk++;
        if (act === bad) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=not %h", req, act, bad);
        end
    endtask

    task automatic push(input logic [31:0] w);
        wr_valid = 1; wr_data = w;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic tport(input logic [31:0] w);
        tport_valid = 1; tport_data = w;
        @(negedge clk);
        tport_valid = 0;
    endtask

    task automatic do_flush();
        flush = 1;
        @(negedge clk);
        flush = 0;
    endtask

    task automatic do_frame();
        frame_end = 1;
        @(negedge clk);
        frame_end = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference walk over the words the bench wrote (R5, R6)
    task automatic ref_walk(input int total);
        longint idx;
        longint len;
        exp_n = 0;
        if (total > 2) begin
            idx = 0;
            while (idx < total - 2) begin
                len = longint'(((words[idx] >> 1) + 32'd2) >> 2);
                if (len == 0) break;
                exp_hdr[exp_n]   = words[idx + 1];
                exp_start[exp_n] = int'(idx) + 2;
                exp_n++;
                idx += len;
            end
        end
    endtask

    task automatic cmp_log(input string req);
        check({req, " request count"}, lg_n, exp_n);
        for (int i = 0; i < exp_n && i < lg_n; i++) begin
            check({req, " header"}, lg_hdr[i], exp_hdr[i]);
            check({req, " start"}, lg_start[i], exp_start[i]);
            check({req, " source"}, {31'd0, lg_rom[i]}, 32'd0);
        end
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) rom_img[i] = 32'h0;
        rom_img[4]  = 32'd22;          // three words
        rom_img[5]  = 32'hCAFE0005;
        rom_img[6]  = 32'h00000066;
        rom_img[10] = 32'd14;
        rom_img[12] = 32'd2;           // zero words

        idle(3);
        @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        check("R1 reset up_valid", {31'd0, up_valid}, 32'd0);
        check("R1 reset overflow_err", {31'd0, overflow_err}, 32'd0);
        check("R1 reset rom_rd_en", {31'd0, rom_rd_en}, 32'd0);

        // Vector table: R4, R5, R6
        for (int v = 0; v < NV; v++) begin
            logic [31:0] w0a, w0b;
            int total, la, expc;
            w0a   = VEC[v][127:96];
            w0b   = VEC[v][95:64];
            total = int'(VEC[v][63:32]);
            expc  = int'(VEC[v][31:0]);
            la    = int'(((w0a >> 1) + 32'd2) >> 2);
            for (int j = 0; j < total; j++) words[j] = 32'h55000000 + j;
            words[0] = w0a;
            if (total > 1) words[1] = 32'hA0000000 + v * 16;
            if (la >= 2 && la + 1 < total) begin
                words[la]     = w0b;
                words[la + 1] = 32'hB0000000 + v * 16;
            end
            lg_n = 0;
            for (int j = 0; j < total; j++) push(words[j]);
            do_flush();
            idle(60);
            ref_walk(total);
            check("R6 table request count", lg_n, expc);
            cmp_log("R5 table");
        end

        // R1 read port and R4 count restart at index 0
        lg_n = 0;
        push(32'd14); push(32'hD1); push(32'hD2);
        rd_addr = 2;
        @(negedge clk);
        check("R1 read port", rd_data, 32'hD2);
        do_flush();
        idle(20);
        check("R4 single packet count", lg_n, 1);
        check("R4 header", lg_hdr[0], 32'hD1);
        check("R4 start index", lg_start[0], 2);

        // R7 backpressure, R8 held flush and dropped write
        lg_n = 0;
        up_ready = 0;
        push(32'd14); push(32'hE1); push(32'hE2); push(32'h77);
        do_flush();
        idle(8);
        check("R7 valid while stalled", {31'd0, up_valid}, 32'd1);
        check("R7 header while stalled", up_header, 32'hE1);
        push(32'h99);
        do_flush();
        idle(3);
        check("R7 header stable", up_header, 32'hE1);
        check("R7 start stable", {28'd0, up_start}, 32'd2);
        check("R7 no transfer while not ready", lg_n, 0);
        up_ready = 1;
        idle(20);
        check("R8 held flush adds no request", lg_n, 1);
        check("R8 no error from dropped write", {31'd0, overflow_err}, 32'd0);
        rd_addr = 4;
        @(negedge clk);
        check_ne("R8 write during flush dropped", rd_data, 32'h99);

        // R2, R3 overflow
        lg_n = 0;
        words[0] = 32'd14;
        words[1] = 32'hF1;
        for (int j = 2; j < DEPTH; j++) words[j] = j;
        for (int j = 0; j < DEPTH; j++) push(words[j]);
        check("R2 no error at exactly full", {31'd0, overflow_err}, 32'd0);
        push(32'h12345);
        check("R2 overflow sets error", {31'd0, overflow_err}, 32'd1);
        push(32'h12346);
        check("R2 error sticky", {31'd0, overflow_err}, 32'd1);
        rd_addr = 4'(DEPTH - 1);
        @(negedge clk);
        check("R2 stored word unchanged", rd_data, DEPTH - 1);
        do_frame();
        check("R3 frame_end clears error", {31'd0, overflow_err}, 32'd0);
        wr_valid = 1; wr_data = 32'h777; frame_end = 1;
        @(negedge clk);
        wr_valid = 0; frame_end = 0;
        check("R3 overflow wins over frame_end", {31'd0, overflow_err}, 32'd1);
        do_frame();
        check("R3 cleared again", {31'd0, overflow_err}, 32'd0);
        do_flush();
        idle(150);
        ref_walk(DEPTH);
        cmp_log("R2 full buffer walk");

        // R9 indirect collection
        lg_n = 0;
        rom_fill_mode = 0;
        tport(32'h12345678); tport(32'hC0DE0001);
        idle(3);
        check("R9 two writes raise nothing", lg_n, 0);
        tport(32'hFFFFFFFF);
        idle(3);
        check("R9 third write raises request", lg_n, 1);
        check("R9 source is ROM", {31'd0, lg_rom[0]}, 32'd1);
        check("R9 ROM address bits 23:0", {8'd0, lg_raddr[0]}, 32'h00345678);
        check("R9 header", lg_hdr[0], 32'hC0DE0001);

        // R10 priority and drop of a second trigger
        lg_n = 0;
        up_ready = 0;
        tport(32'h10); tport(32'hB1); tport(32'h0);
        tport(32'h20); tport(32'hB2); tport(32'h0);
        push(32'd14); push(32'hAB); push(32'h0);
        do_flush();
        idle(10);
        check("R10 ROM request offered first", {31'd0, up_from_rom}, 32'd1);
        up_ready = 1;
        idle(20);
        check("R10 request count", lg_n, 2);
        check("R10 first is ROM header", lg_hdr[0], 32'hB1);
        check("R10 first ROM address", {8'd0, lg_raddr[0]}, 32'h10);
        check("R10 second is parser header", lg_hdr[1], 32'hAB);
        check("R10 second source", {31'd0, lg_rom[1]}, 32'd0);
        tport(32'h30); tport(32'hB3); tport(32'h0);
        idle(3);
        check("R10 collection restarted", lg_n, 3);
        check("R10 restarted header", lg_hdr[2], 32'hB3);
        check("R10 restarted address", {8'd0, lg_raddr[2]}, 32'h30);

        // R11 ROM-fill copy, R12 write during copy ignored
        lg_n = 0;
        rom_fill_mode = 1;
        tport(32'hAB000004);
        tport(32'h0000000A);
        idle(20);
        rom_fill_mode = 0;
        do_flush();
        idle(20);
        check("R11 copied packet request count", lg_n, 1);
        check("R11 copied header", lg_hdr[0], 32'hCAFE0005);
        check("R11 copied start", lg_start[0], 2);
        rd_addr = 2;
        @(negedge clk);
        check("R11 copied third word", rd_data, 32'h66);
        rd_addr = 3;
        @(negedge clk);
        check_ne("R12 port write during copy ignored", rd_data, 32'd14);

        // R12 zero-length ROM packet copies nothing
        lg_n = 0;
        rom_fill_mode = 1;
        tport(32'h0000000C);
        idle(10);
        rom_fill_mode = 0;
        push(32'd14); push(32'h78); push(32'h0);
        do_flush();
        idle(20);
        check("R12 zero count copies nothing: count", lg_n, 1);
        check("R12 zero count copies nothing: header", lg_hdr[0], 32'h78);
        check("R12 zero count copies nothing: start", lg_start[0], 2);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule